// File: doc/BRIEF.md
# Four-Phase Handshake Stage Controller

This block is a clocked model of the control half of a bundled-data self-timed pipeline stage. Upstream, a sender raises `req_in` with data on `din` and waits for `ack_in`. Downstream, the stage raises `req_out` with its result on `dout` and waits for `ack_out`. Between the two channels the controller drives `start` into a datapath model and waits for that model's `done`.

The datapath's completion is a matched delay: a down-counter loaded from `DELAY` that raises `done` a fixed number of cycles after `start` rises. It drops `done` the same number of cycles after `start` falls. Both channels follow return-to-zero signalling. Every edge on the block's outputs waits for the preceding event in one fixed chain, so the two handshakes are tied together through the `start`/`done` pair.

The datapath result is the captured operand plus one, modulo 2^WIDTH. A sticky flag records any environment input edge that arrives out of turn.

Top module: `hs4_stage_ctrl`

## Requirements
- R1: After reset, `ack_in`, `start`, `done`, `req_out` and `proto_err` are all 0.
- R2: When idle, `start` rises on the clock edge that samples `req_in` high, and `din` is captured on that same edge. While `req_in` is low in idle, `start` stays 0 whatever `din` does.
- R3: `done` rises exactly `DELAY` cycles after `start` rises. `done` falls exactly `DELAY` cycles after `start` falls.
- R4: `req_out` rises one cycle after `done` rises and not before. At that point `dout` equals the captured operand plus one, modulo 2^WIDTH.
- R5: `ack_in` stays 0 while `ack_out` is low. `ack_in` rises on the edge that samples `ack_out` high while `req_out` is high.
- R6: `start` stays high until `req_in` is sampled low with `ack_in` high, and falls on that edge.
- R7: `req_out` falls one cycle after `done` falls. `ack_in` falls on the edge that samples `ack_out` low while `req_out` is low.
- R8: `dout` holds its value from before `req_out` rises until the next computation, regardless of later changes on `din`.
- R9: `proto_err` becomes 1 one edge after any of these input edges, and then stays 1 until reset:
  - `req_in` falls while `ack_in` is 0;
  - `req_in` rises while `ack_in` is 1;
  - `ack_out` rises while `req_out` is 0;
  - `ack_out` falls while `req_out` is 1.
- R10: A legal sequence of handshakes never sets `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 1 | Upstream request |
| ack_in | output | 1 | Upstream acknowledge |
| din | input | WIDTH | Upstream bundled data |
| start | output | 1 | Datapath compute (1) / reset (0) |
| done | output | 1 | Matched-delay completion |
| req_out | output | 1 | Downstream request |
| ack_out | input | 1 | Downstream acknowledge |
| dout | output | WIDTH | Downstream bundled result |
| proto_err | output | 1 | Sticky out-of-order input flag |

## Verification
The ordering assertions on the output edges hold whatever the environment does. The stability property on `dout` relies on the downstream side raising `ack_out` only while `req_out` is high. The delay-window properties assume no reset lands inside a computation.

The random stimulus keeps both neighbours legal: each input edge waits until the controller's matching output has been seen at a falling clock edge, and `din` is scrambled only while no request is pending. The illegal edges are confined to four directed cases, and each one is followed by a reset.

// File: rtl/hs4_stage_ctrl.sv
module hs4_stage_ctrl #(
  parameter int WIDTH = 8,
  parameter int DELAY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_in,
  output logic             ack_in,
  input  logic [WIDTH-1:0] din,
  output logic             start,
  output logic             done,
  output logic             req_out,
  input  logic             ack_out,
  output logic [WIDTH-1:0] dout,
  output logic             proto_err
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CALC, S_HOLD, S_WAIT_AO, S_WAIT_RI, S_DRAIN, S_DROP, S_WAIT_AL
  } st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [WIDTH-1:0] opnd;
  logic            req_in_q, ack_out_q;
  logic            bad_edge;

  assign bad_edge = ( req_in_q & ~req_in  & ~ack_in ) |
                    (~req_in_q &  req_in  &  ack_in ) |
                    (~ack_out_q & ack_out & ~req_out) |
                    ( ack_out_q & ~ack_out & req_out);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_in_q  <= 1'b0;
      ack_out_q <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      req_in_q  <= req_in;
      ack_out_q <= ack_out;
      proto_err <= proto_err | bad_edge;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      opnd    <= '0;
      dout    <= '0;
      start   <= 1'b0;
      done    <= 1'b0;
      req_out <= 1'b0;
      ack_in  <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (req_in) begin
            start <= 1'b1;
            cnt   <= LOAD;
            opnd  <= din;
            st    <= S_CALC;
          end
        S_CALC:
          if (cnt == '0) begin
            done <= 1'b1;
            dout <= opnd + 1'b1;
            st   <= S_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_HOLD: begin
          req_out <= 1'b1;
          st      <= S_WAIT_AO;
        end
        S_WAIT_AO:
          if (ack_out) begin
            ack_in <= 1'b1;
            st     <= S_WAIT_RI;
          end
        S_WAIT_RI:
          if (!req_in) begin
            start <= 1'b0;
            cnt   <= LOAD;
            st    <= S_DRAIN;
          end
        S_DRAIN:
          if (cnt == '0) begin
            done <= 1'b0;
            st   <= S_DROP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_DROP: begin
          req_out <= 1'b0;
          st      <= S_WAIT_AL;
        end
        S_WAIT_AL:
          if (!ack_out) begin
            ack_in <= 1'b0;
            st     <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] win;
  always_ff @(posedge clk) begin
    if (!rst_n)            win <= '0;
    else if (start != done) win <= win + 1'b1;
    else                    win <= '0;
  end

  p_start_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |-> $past(req_in) && !ack_in);
  p_done_rise_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> start && win == CW'(DELAY));
  p_done_fall_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> !start && win == CW'(DELAY));
  p_req_out_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_out) |-> done && $past(done));
  p_ack_in_after_ack_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_in) |-> $past(ack_out) && req_out);
  p_start_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start) |-> !$past(req_in) && ack_in && done);
  p_req_out_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_out) |-> !done && !start);
  p_ack_in_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_in) |-> !$past(ack_out) && !req_out);
  p_dout_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out && !ack_out) |-> $stable(dout));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

// File: tb/test_hs4_stage_ctrl.sv
module test_hs4_stage_ctrl;
  localparam int W = 8;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n, req_in, ack_out;
  logic [W-1:0] din;
  logic ack_in, start, done, req_out, proto_err;
  logic [W-1:0] dout;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  hs4_stage_ctrl #(.WIDTH(W), .DELAY(D)) i_hs4_stage_ctrl (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_in(ack_in), .din(din),
    .start(start), .done(done), .req_out(req_out), .ack_out(ack_out),
    .dout(dout), .proto_err(proto_err));

  function automatic logic [W-1:0] exp_res(input logic [W-1:0] d);
    return d + 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_in = 1'b0; ack_out = 1'b0; din = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic txn(input logic [W-1:0] d, input int ao_lat, input int ri_lat);
    int n;
    din = d; req_in = 1'b1;
    step();
    check(start == 1'b1, "R2 start rise", start, 1);
    n = 0;
    while (!done && n < D + 5) begin step(); n++; end
    check(n == D, "R3 done rise delay", n, D);
    check(req_out == 1'b0, "R4 req_out waits for done", req_out, 0);
    step();
    check(req_out == 1'b1, "R4 req_out rise", req_out, 1);
    check(dout == exp_res(d), "R4 result", dout, exp_res(d));
    for (int i = 0; i < ao_lat; i++) begin
      step();
      check(ack_in == 1'b0, "R5 ack_in waits", ack_in, 0);
    end
    ack_out = 1'b1;
    step();
    check(ack_in == 1'b1, "R5 ack_in rise", ack_in, 1);
    check(dout == exp_res(d), "R8 dout held", dout, exp_res(d));
    for (int i = 0; i < ri_lat; i++) begin
      step();
      check(start == 1'b1, "R6 start held", start, 1);
    end
    req_in = 1'b0; din = W'($urandom);
    step();
    check(start == 1'b0, "R6 start fall", start, 0);
    n = 0;
    while (done && n < D + 5) begin step(); n++; din = W'($urandom); end
    check(n == D, "R3 done fall delay", n, D);
    check(req_out == 1'b1, "R7 req_out waits for done fall", req_out, 1);
    step();
    check(req_out == 1'b0, "R7 req_out fall", req_out, 0);
    check(dout == exp_res(d), "R8 din change ignored", dout, exp_res(d));
    ack_out = 1'b0;
    step();
    check(ack_in == 1'b0, "R7 ack_in fall", ack_in, 0);
    check(proto_err == 1'b0, "R10 legal sequence no error", proto_err, 0);
  endtask

  task automatic to_req_out();
    int n;
    req_in = 1'b1;
    n = 0;
    while (!req_out && n < D + 8) begin step(); n++; end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    check({ack_in, start, done, req_out, proto_err} == 5'b0, "R1 reset state",
          {ack_in, start, done, req_out, proto_err}, 0);

    for (int i = 0; i < 4; i++) begin
      din = W'($urandom);
      step();
      check(start == 1'b0, "R2 idle ignores din", start, 0);
    end

    txn(8'hFF, 0, 0);
    check(dout == 8'h00, "R4 wrap result", dout, 0);
    txn(8'h00, 3, 2);
    for (int t = 0; t < 25; t++)
      txn(W'($urandom), int'($urandom_range(0, 4)), int'($urandom_range(0, 4)));

    do_reset();
    ack_out = 1'b1;
    step(); step();
    check(proto_err == 1'b1, "R9 ack_out rise without req_out", proto_err, 1);
    ack_out = 1'b0;
    step(); step();
    check(proto_err == 1'b1, "R9 sticky", proto_err, 1);

    do_reset();
    req_in = 1'b1;
    step(); step();
    req_in = 1'b0;
    step(); step();
    check(proto_err == 1'b1, "R9 req_in fall before ack_in", proto_err, 1);

    do_reset();
    to_req_out();
    ack_out = 1'b1;
    step();
    ack_out = 1'b0;
    step(); step();
    check(proto_err == 1'b1, "R9 ack_out fall with req_out high", proto_err, 1);

    do_reset();
    to_req_out();
    ack_out = 1'b1;
    step();
    req_in = 1'b0;
    step();
    check(proto_err == 1'b0, "R10 legal so far", proto_err, 0);
    req_in = 1'b1;
    step(); step();
    check(proto_err == 1'b1, "R9 req_in rise with ack_in high", proto_err, 1);

    do_reset();
    check(proto_err == 1'b0, "R1 reset clears error", proto_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule